// File: doc/BRIEF.md
# Serial Sampling-Converter Read Controller

This block is the host-side master that fetches one sample from a serial successive-approximation converter. A request carries a channel-assignment word. The controller then drops chip select and builds the converter clock itself by dividing the system clock. It sends a start bit followed by the channel word on the converter's data input. It lets one serial period pass for multiplexer settling, ignoring the dummy zero returned in that slot. It then gathers eight result bits, most significant first.

The converter changes its output on falling serial edges, so the controller latches each bit at the next rising edge. When the last bit is in, the controller raises chip select and parks the serial clock low. It presents the result with a one-cycle done pulse. It then keeps chip select high for a full serial period before it will accept the next request.

Top module: `serial_adc_reader`

## Requirements
- R1: While reset is asserted and after it is released with no request, chip select (`adc_cs_n`) is high, `adc_sclk` is low, `adc_din` is low, and `done` and `busy` are low.
- R2: A request (`req_valid` high) seen while `busy` is low makes `adc_cs_n` go low and `busy` go high on the next clock edge.
- R3: While `adc_cs_n` is low, every low and every high phase of `adc_sclk` lasts exactly CLK_DIV system clocks, and the first phase is low. Whenever `adc_cs_n` is high, `adc_sclk` is low.
- R4: In serial period 0, `adc_din` carries a 1 as the start bit. In periods 1 to MUX_W it carries the latched channel word, most significant bit first. `adc_din` changes only while `adc_sclk` is low.
- R5: The serial period after the channel word is a settling slot. Whatever `adc_dout` carries in that slot does not enter the result.
- R6: In each of the next 8 serial periods, `adc_dout` is sampled on the rising edge of `adc_sclk`, and the first sample becomes result bit 7. A frame contains exactly MUX_W+10 rising edges.
- R7: `done` is high for exactly one clock with `result` valid. In that same cycle `adc_cs_n` has just risen and `adc_sclk` is low.
- R8: A request made while `busy` is high is dropped. It does not alter the frame in progress and it does not start a later frame.
- R9: Between two frames, `adc_cs_n` stays high for at least 2*CLK_DIV system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_valid | input | 1 | Read request, taken only when idle |
| req_mux | input | MUX_W | Channel-assignment word sent after the start bit |
| busy | output | 1 | High from acceptance until the inter-frame gap ends |
| done | output | 1 | One-cycle pulse marking a new result |
| result | output | RES_W | Last converted sample |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_sclk | output | 1 | Generated converter clock |
| adc_din | output | 1 | Command bits to the converter |
| adc_dout | input | 1 | Serial result from the converter |

## Verification
The bench contains a behavioural converter model. This model ignores leading zeros, decodes the start bit and channel word on rising edges, drives a dummy zero and then the sample on falling edges, and idles its output high. Channel words are chosen so that each one selects a different sample. All-zero, all-one and alternating samples show whether any bit was shifted, so a misaligned settling slot or a wrong bit order becomes visible, and the model's decoded channel shows a wrong command order. A request made in the middle of a frame shows whether a busy request is really dropped. A request held high across frame boundaries shows whether the inter-frame gap is kept at its minimum length.

// File: rtl/sadc_pkg.sv
package sadc_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_FRAME = 2'd1,
    SQ_GUARD = 2'd2
  } sq_state_e;

  // serial periods per frame: start + word + settle + result bits
  function automatic int frame_periods(int mux_w, int res_w);
    return 1 + mux_w + 1 + res_w;
  endfunction

endpackage

// File: rtl/sadc_half_timer.sv
module sadc_half_timer #(
  parameter int CLK_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CNT_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CLK_DIV - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (!run)             cnt_d = '0;
    else if (cnt_q == LAST) cnt_d = '0;
    else                  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = run && (cnt_q == LAST);
endmodule

// File: rtl/sadc_frame_seq.sv
module sadc_frame_seq
  import sadc_pkg::*;
#(
  parameter int MUX_W = 3,
  parameter int RES_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             req_valid,
  input  logic [MUX_W-1:0] req_mux,
  output logic             run,
  output logic             cs_n,
  output logic             sclk,
  output logic             din,
  output logic             sample_en,
  output logic             frame_end
);
  localparam int NPER      = frame_periods(MUX_W, RES_W);
  localparam int PER_W     = $clog2(NPER);
  localparam int FIRST_RES = MUX_W + 2;
  localparam logic [PER_W-1:0] LAST_PER = PER_W'(NPER - 1);
  localparam logic [PER_W-1:0] RES_PER  = PER_W'(FIRST_RES);

  sq_state_e        state_q, state_d;
  logic             ph_q, ph_d;          // 0 = low half, 1 = high half
  logic [PER_W-1:0] per_q, per_d;
  logic [MUX_W-1:0] mux_q, mux_d;
  logic             cs_n_q, cs_n_d;
  logic             sclk_q, sclk_d;
  logic             din_q, din_d;

  // command bit for a given serial period
  function automatic logic cmd_bit(logic [PER_W-1:0] p, logic [MUX_W-1:0] w);
    int idx;
    if (p == '0) return 1'b1;
    if (int'(p) <= MUX_W) begin
      idx = MUX_W - int'(p);
      return w[idx];
    end
    return 1'b0;
  endfunction

  always_comb begin
    state_d = state_q;
    ph_d    = ph_q;
    per_d   = per_q;
    mux_d   = mux_q;
    cs_n_d  = cs_n_q;
    sclk_d  = sclk_q;
    din_d   = din_q;
    case (state_q)
      SQ_IDLE: begin
        if (req_valid) begin
          state_d = SQ_FRAME;
          mux_d   = req_mux;
          cs_n_d  = 1'b0;
          sclk_d  = 1'b0;
          ph_d    = 1'b0;
          per_d   = '0;
          din_d   = 1'b1;
        end
      end
      SQ_FRAME: begin
        if (tick) begin
          if (!ph_q) begin
            ph_d   = 1'b1;
            sclk_d = 1'b1;
          end else begin
            ph_d   = 1'b0;
            sclk_d = 1'b0;
            if (per_q == LAST_PER) begin
              state_d = SQ_GUARD;
              cs_n_d  = 1'b1;
              din_d   = 1'b0;
              per_d   = '0;
            end else begin
              per_d = per_q + 1'b1;
              din_d = cmd_bit(per_q + 1'b1, mux_q);
            end
          end
        end
      end
      SQ_GUARD: begin
        if (tick) begin
          if (!ph_q) ph_d = 1'b1;
          else begin
            ph_d    = 1'b0;
            state_d = SQ_IDLE;
          end
        end
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      ph_q    <= 1'b0;
      per_q   <= '0;
      mux_q   <= '0;
      cs_n_q  <= 1'b1;
      sclk_q  <= 1'b0;
      din_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      ph_q    <= ph_d;
      per_q   <= per_d;
      mux_q   <= mux_d;
      cs_n_q  <= cs_n_d;
      sclk_q  <= sclk_d;
      din_q   <= din_d;
    end
  end

  assign run       = (state_q != SQ_IDLE);
  assign cs_n      = cs_n_q;
  assign sclk      = sclk_q;
  assign din       = din_q;
  assign sample_en = (state_q == SQ_FRAME) && tick && !ph_q && (per_q >= RES_PER);
  assign frame_end = (state_q == SQ_FRAME) && tick && ph_q && (per_q == LAST_PER);
endmodule

// File: rtl/sadc_rx_shift.sv
module sadc_rx_shift #(
  parameter int RES_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample_en,
  input  logic             frame_end,
  input  logic             sdata,
  output logic [RES_W-1:0] result,
  output logic             done
);
  logic [RES_W-1:0] shreg_q, shreg_d;
  logic [RES_W-1:0] res_q, res_d;
  logic             done_q;

  always_comb begin
    shreg_d = sample_en ? {shreg_q[RES_W-2:0], sdata} : shreg_q;
    res_d   = frame_end ? shreg_q : res_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      res_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      shreg_q <= shreg_d;
      res_q   <= res_d;
      done_q  <= frame_end;
    end
  end

  assign result = res_q;
  assign done   = done_q;
endmodule

// File: rtl/serial_adc_reader.sv
module serial_adc_reader #(
  parameter int CLK_DIV = 4,
  parameter int MUX_W   = 3,
  parameter int RES_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [MUX_W-1:0] req_mux,
  output logic             busy,
  output logic             done,
  output logic [RES_W-1:0] result,
  output logic             adc_cs_n,
  output logic             adc_sclk,
  output logic             adc_din,
  input  logic             adc_dout
);
  logic run, tick, sample_en, frame_end;

  sadc_half_timer #(.CLK_DIV(CLK_DIV)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run),
    .tick (tick)
  );

  sadc_frame_seq #(.MUX_W(MUX_W), .RES_W(RES_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .req_valid(req_valid),
    .req_mux  (req_mux),
    .run      (run),
    .cs_n     (adc_cs_n),
    .sclk     (adc_sclk),
    .din      (adc_din),
    .sample_en(sample_en),
    .frame_end(frame_end)
  );

  sadc_rx_shift #(.RES_W(RES_W)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .sample_en(sample_en),
    .frame_end(frame_end),
    .sdata    (adc_dout),
    .result   (result),
    .done     (done)
  );

  assign busy = run;
endmodule

// File: rtl/sadc_reader_checker.sv
module sadc_reader_checker #(
  parameter int CLK_DIV = 4,
  parameter int MUX_W   = 3,
  parameter int RES_W   = 8
) (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic busy,
  input logic done,
  input logic adc_cs_n,
  input logic adc_sclk,
  input logic adc_din
);
  localparam int GAP    = 2 * CLK_DIV;
  localparam int NRISE  = MUX_W + RES_W + 2;

  logic [31:0] hi_cnt;
  logic [31:0] rise_cnt;
  logic        sclk_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt   <= 32'(GAP);
      rise_cnt <= '0;
      sclk_d   <= 1'b0;
    end else begin
      sclk_d <= adc_sclk;
      if (adc_cs_n) hi_cnt <= (hi_cnt >= 32'(GAP)) ? hi_cnt : hi_cnt + 1;
      else          hi_cnt <= '0;
      if (adc_cs_n)                      rise_cnt <= '0;
      else if (adc_sclk && !sclk_d)      rise_cnt <= rise_cnt + 1;
    end
  end

  assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_valid) |=> (!adc_cs_n && busy));

  assert_sclk_idle_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    adc_cs_n |-> !adc_sclk);

  assert_din_steady_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!adc_cs_n && adc_sclk) |-> $stable(adc_din));

  assert_frame_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (rise_cnt == 32'(NRISE)));

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_with_cs_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($rose(adc_cs_n) && !adc_sclk));

  assert_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adc_cs_n) |-> (hi_cnt >= 32'(GAP)));
endmodule

bind serial_adc_reader sadc_reader_checker #(
  .CLK_DIV(CLK_DIV), .MUX_W(MUX_W), .RES_W(RES_W)
) u_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .busy     (busy),
  .done     (done),
  .adc_cs_n (adc_cs_n),
  .adc_sclk (adc_sclk),
  .adc_din  (adc_din)
);

// File: tb/serial_adc_reader_bench.sv
module serial_adc_reader_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_DIV    = 3;
  localparam int MUX_W      = 3;
  localparam int RES_W      = 8;
  localparam int NRISE      = MUX_W + RES_W + 2;

  logic             clk;
  logic             rst_n;
  logic             req_valid;
  logic [MUX_W-1:0] req_mux;
  logic             busy, done;
  logic [RES_W-1:0] result;
  logic             adc_cs_n, adc_sclk, adc_din;
  logic             dout_r;

  int n_checks = 0;
  int n_fail   = 0;
  int frames   = 0;
  logic [MUX_W-1:0] exp_q[$];

  serial_adc_reader #(.CLK_DIV(CLK_DIV), .MUX_W(MUX_W), .RES_W(RES_W)) u_serial_adc_reader (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mux(req_mux),
    .busy(busy), .done(done), .result(result),
    .adc_cs_n(adc_cs_n), .adc_sclk(adc_sclk), .adc_din(adc_din), .adc_dout(dout_r)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [RES_W-1:0] val_for(logic [MUX_W-1:0] ch);
    case (ch)
      3'd0:    return 8'h00;
      3'd7:    return 8'hFF;
      3'd5:    return 8'hA5;
      3'd2:    return 8'h5A;
      default: return 8'((int'(ch) * 37 + 11) & 255);
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // converter model
  int m_state, m_bits, m_oidx, m_rises;
  logic [MUX_W-1:0] m_chan;
  logic [RES_W-1:0] m_val;
  initial dout_r = 1'b1;

  always @(negedge adc_cs_n) begin
    m_state = 0; m_bits = 0; m_rises = 0; m_chan = '0;
  end
  always @(posedge adc_cs_n) dout_r <= 1'b1;

  always @(posedge adc_sclk) if (!adc_cs_n) begin
    m_rises++;
    if (m_state == 0) begin
      if (adc_din) m_state = 1;
    end else if (m_state == 1) begin
      m_chan = {m_chan[MUX_W-2:0], adc_din};
      m_bits++;
      if (m_bits == MUX_W) m_state = 2;
    end
  end

  always @(negedge adc_sclk) if (!adc_cs_n) begin
    if (m_state == 2) begin
      dout_r <= 1'b0;               // dummy settling zero
      m_state = 3;
      m_oidx  = RES_W - 1;
      m_val   = val_for(m_chan);
    end else if (m_state == 3 && m_oidx >= 0) begin
      dout_r <= m_val[m_oidx];
      m_oidx--;
    end
  end

  // monitor: timing tracker and scoreboard
  logic prev_cs = 1'b1, prev_sclk = 1'b0, prev_done = 1'b0;
  int run_len = 0, half_bad = 0, gap_len = 0;
  bit seen_frame = 0;

  always @(negedge clk) if (rst_n) begin
    if (!adc_cs_n) begin
      if (prev_cs) begin
        if (seen_frame)
          chk(gap_len >= 2*CLK_DIV, "R9", "cs high gap", 32'(gap_len), 32'(2*CLK_DIV));
        run_len = 1; half_bad = 0;
        chk(!adc_sclk, "R3", "first phase low", 32'(adc_sclk), 32'd0);
      end else if (adc_sclk != prev_sclk) begin
        if (run_len != CLK_DIV) half_bad++;
        run_len = 1;
      end else run_len++;
    end else begin
      if (!prev_cs) begin
        if (run_len != CLK_DIV) half_bad++;
        gap_len = 1;
        seen_frame = 1;
      end else gap_len++;
    end

    if (prev_done)
      chk(!done, "R7", "done width", 32'(done), 32'd0);

    if (done) begin
      frames++;
      if (exp_q.size() == 0) begin
        chk(1'b0, "R8", "unexpected result", 32'(result), 32'd0);
      end else begin
        logic [MUX_W-1:0] e;
        e = exp_q.pop_front();
        chk(result == val_for(e), "R5 R6", "result", 32'(result), 32'(val_for(e)));
        chk(m_chan == e, "R4", "decoded channel", 32'(m_chan), 32'(e));
        chk(m_rises == NRISE, "R6", "rising edges", 32'(m_rises), 32'(NRISE));
        chk(adc_cs_n && !adc_sclk, "R7", "cs/sclk at done",
            {30'd0, adc_cs_n, adc_sclk}, 32'd2);
        chk(half_bad == 0, "R3", "bad half periods", 32'(half_bad), 32'd0);
      end
    end
    prev_cs   = adc_cs_n;
    prev_sclk = adc_sclk;
    prev_done = done;
  end

  // driver
  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic issue(input logic [MUX_W-1:0] ch);
    wait_idle();
    req_valid = 1'b1;
    req_mux   = ch;
    exp_q.push_back(ch);
    @(negedge clk);
    chk(!adc_cs_n && busy, "R2", "accept", {30'd0, adc_cs_n, busy}, 32'd1);
    req_valid = 1'b0;
  endtask

  task automatic wait_frames(input int target);
    while (frames < target) @(negedge clk);
  endtask

  // watchdog
  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", wd, 100000);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_mux = '0;
    repeat (4) @(negedge clk);
    chk(adc_cs_n && !adc_sclk && !adc_din && !done && !busy, "R1", "in reset",
        {27'd0, adc_cs_n, adc_sclk, adc_din, done, busy}, 32'h10);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(adc_cs_n && !adc_sclk && !adc_din && !done && !busy, "R1", "after release",
        {27'd0, adc_cs_n, adc_sclk, adc_din, done, busy}, 32'h10);

    // every channel word, one frame each
    for (int c = 0; c < (1 << MUX_W); c++) begin
      issue(MUX_W'(c));
      wait_frames(c + 1);
      @(negedge clk);
      chk(!adc_din && adc_cs_n, "R1", "idle lines after frame",
          {30'd0, adc_din, adc_cs_n}, 32'd1);
    end

    // R8: request during a busy frame is dropped
    issue(3'd2);
    repeat (10) @(negedge clk);
    req_valid = 1'b1; req_mux = 3'd5;
    @(negedge clk);
    req_valid = 1'b0;
    wait_frames((1 << MUX_W) + 1);
    repeat (6 * CLK_DIV) @(negedge clk);
    chk(adc_cs_n && !busy, "R8", "no frame after busy request",
        {30'd0, adc_cs_n, busy}, 32'd2);
    chk(frames == (1 << MUX_W) + 1, "R8", "frame count", 32'(frames), 32'((1 << MUX_W) + 1));

    // R9: request held high across a frame boundary
    wait_idle();
    req_valid = 1'b1; req_mux = 3'd4;
    exp_q.push_back(3'd4);
    @(negedge clk);
    req_mux = 3'd6;
    exp_q.push_back(3'd6);
    wait_frames((1 << MUX_W) + 2);
    while (adc_cs_n) @(negedge clk);
    req_valid = 1'b0;
    wait_frames((1 << MUX_W) + 3);
    repeat (4 * CLK_DIV) @(negedge clk);

    chk(exp_q.size() == 0, "R8", "pending expectations", 32'(exp_q.size()), 32'd0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule